// File: doc/BRIEF.md
# Hashed Page Table Group Matcher

This block looks up one translation inside a single group of eight hashed page table entries. Each entry is a pair of 64-bit doublewords. The first doubleword carries the lookup key and the flag bits. The second doubleword carries the real page number and the access bits. Software, or a refill engine, fills the eight slots through a simple write port. A search is then launched with a target first doubleword and a bit that says whether the primary or the secondary hash is being searched.

After a one-cycle `start` pulse, the block visits slot 0, then slot 1, and so on, one slot per clock. It stops at the first slot that is valid, carries the right hash flag and agrees with the target on the key bits. It then raises `done` for one cycle, together with `hit`, the slot number and that slot's second doubleword. If no slot matches, it raises `done` after slot 7 and reports zeros. The target's key is the 2-bit segment size in bits 63..62 followed by the abbreviated page number in bits 61..7. The flag bits 6..0 take no part in the key comparison.

Top module: `hpte_group_matcher`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `hit`, `slot` and `hit_second` are all zero.
- R2: Key comparison uses first-doubleword bits 63..7 only. Entries and targets that differ only in bits 6..0 still match, for example on the large-page flag (bit 2) or the bolted flag (bit 4).
- R3: An entry whose valid flag (bit 0 of the first doubleword) is clear never matches, even when its key bits are equal.
- R4: An entry matches only when its secondary-hash flag (bit 1 of the first doubleword) equals `sec_sel`.
- R5: The lock flag (bit 3 of the first doubleword) does not prevent a match.
- R6: Slots are visited in ascending order and the lowest matching slot wins. A hit in slot s raises `done` exactly s+1 clock edges after the edge that samples `start`.
- R7: On a miss, `done` rises exactly 8 edges after the edge that samples `start`, with `hit`, `slot` and `hit_second` all zero.
- R8: `done` lasts one cycle. `hit`, `slot` and `hit_second` are zero in every cycle where `done` is low.
- R9: A `start` pulse that arrives while a search is running is ignored. The running search finishes with its own target.
- R10: The segment-size bits 63..62 are part of the key, so a difference in bit 62 alone gives a miss.
- R11: A write through the port replaces both doublewords of the addressed slot. Later searches see only the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write one slot of the group |
| wr_idx | input | 3 | Slot to write |
| wr_first | input | 64 | First doubleword to store |
| wr_second | input | 64 | Second doubleword to store |
| start | input | 1 | One-cycle pulse that launches a search |
| target | input | 64 | Target first doubleword (key in bits 63..7) |
| sec_sel | input | 1 | 1 when searching with the secondary hash |
| done | output | 1 | One-cycle pulse at search end |
| hit | output | 1 | Search found a matching slot |
| slot | output | 3 | Index of the matching slot, zero on a miss |
| hit_second | output | 64 | Second doubleword of the matching slot, zero on a miss |

## Verification
The tests load groups in several ways:
- A lone match in a middle slot and a match in slot 7 pin down the per-slot latency.
- Two equal keys check that the lower slot wins.
- Keys equal to the target but with the valid flag clear, or the secondary flag wrong, separate the flag qualification from the key compare.
- Targets and entries whose low flag bits, lock bit included, differ from each other show that those bits are masked out.
- A single flipped segment-size bit shows that the top bits are kept in the key.
- An empty group gives the miss timing.
- A second `start` during a scan and a slot overwrite check that only the first target and the newest contents count.

// File: rtl/hgm_pkg.sv
// Shared constants and types for the hashed page table group matcher.
// Assumes a fixed two-doubleword entry; bit positions follow the table format.
package hgm_pkg;
    parameter int DW        = 64;  // doubleword width
    parameter int SLOTS     = 8;   // entries per group
    parameter int IDXW      = $clog2(SLOTS);
    parameter int KEY_LSB   = 7;   // lowest key bit of the first doubleword
    parameter int VALID_BIT = 0;
    parameter int SEC_BIT   = 1;

    localparam logic [DW-1:0] KEY_MASK = {{(DW-KEY_LSB){1'b1}}, {KEY_LSB{1'b0}}};

    typedef struct packed {
        logic [DW-1:0] first;
        logic [DW-1:0] second;
    } hgm_entry_t;
endpackage

// File: rtl/hgm_entry_store.sv
// Register array holding one group of entries.
// One write port, one combinational read port; reset empties every slot.
module hgm_entry_store
    import hgm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  hgm_entry_t       wr_data,
    input  logic [IDXW-1:0]  rd_idx,
    output hgm_entry_t       rd_data
);
    hgm_entry_t mem [SLOTS];

    // One register row per slot, written when addressed.
    for (genvar g = 0; g < SLOTS; g++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (wr_en && wr_idx == IDXW'(g))
                mem[g] <= wr_data;
        end
    end

    // Read mux for the slot under scan.
    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/hgm_slot_compare.sv
// Qualifies one entry against the target.
// Match needs the valid flag, the right hash flag and equal key bits.
module hgm_slot_compare
    import hgm_pkg::*;
(
    input  logic [DW-1:0] entry_first,
    input  logic [DW-1:0] tgt_first,
    input  logic          sel_secondary,
    output logic          match
);
    logic [DW-1:0] diff;

    // Key difference with the flag bits masked away.
    always_comb begin
        diff  = (entry_first ^ tgt_first) & KEY_MASK;
        match = entry_first[VALID_BIT]
              && (entry_first[SEC_BIT] == sel_secondary)
              && (diff == '0);
    end
endmodule

// File: rtl/hgm_scan_ctrl.sv
// Scan sequencer: captures the target on start, steps one slot per clock,
// stops at the first match or after the last slot, and pulses the result.
// Assumes the group is not written while a scan is running.
module hgm_scan_ctrl
    import hgm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DW-1:0]    target,
    input  logic             sec_sel,
    input  logic             match,
    input  logic [DW-1:0]    cur_second,
    output logic [IDXW-1:0]  cur_idx,
    output logic [DW-1:0]    tgt_q,
    output logic             sel_q,
    output logic             done,
    output logic             hit,
    output logic [IDXW-1:0]  slot,
    output logic [DW-1:0]    hit_second
);
    localparam logic [IDXW-1:0] LAST = IDXW'(SLOTS - 1);

    logic busy;

    // Sequencer state and registered result outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            cur_idx    <= '0;
            tgt_q      <= '0;
            sel_q      <= 1'b0;
            done       <= 1'b0;
            hit        <= 1'b0;
            slot       <= '0;
            hit_second <= '0;
        end else begin
            done       <= 1'b0;
            hit        <= 1'b0;
            slot       <= '0;
            hit_second <= '0;
            if (busy) begin
                if (match) begin
                    busy       <= 1'b0;
                    done       <= 1'b1;
                    hit        <= 1'b1;
                    slot       <= cur_idx;
                    hit_second <= cur_second;
                end else if (cur_idx == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cur_idx <= cur_idx + 1'b1;
                end
            end else if (start) begin
                busy    <= 1'b1;
                cur_idx <= '0;
                tgt_q   <= target;
                sel_q   <= sec_sel;
            end
        end
    end
endmodule

// File: rtl/hpte_group_matcher.sv
// Top: searches a group of eight hashed page table entries for a
// translation, one slot per clock, reporting the first qualified match.
module hpte_group_matcher
    import hgm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [DW-1:0]    wr_first,
    input  logic [DW-1:0]    wr_second,
    input  logic             start,
    input  logic [DW-1:0]    target,
    input  logic             sec_sel,
    output logic             done,
    output logic             hit,
    output logic [IDXW-1:0]  slot,
    output logic [DW-1:0]    hit_second
);
    hgm_entry_t       wr_data;
    hgm_entry_t       rd_data;
    logic [IDXW-1:0]  cur_idx;
    logic [DW-1:0]    tgt_q;
    logic             sel_q;
    logic             match;

    assign wr_data = '{first: wr_first, second: wr_second};

    hgm_entry_store u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (cur_idx),
        .rd_data (rd_data)
    );

    hgm_slot_compare u_cmp (
        .entry_first   (rd_data.first),
        .tgt_first     (tgt_q),
        .sel_secondary (sel_q),
        .match         (match)
    );

    hgm_scan_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .target     (target),
        .sec_sel    (sec_sel),
        .match      (match),
        .cur_second (rd_data.second),
        .cur_idx    (cur_idx),
        .tgt_q      (tgt_q),
        .sel_q      (sel_q),
        .done       (done),
        .hit        (hit),
        .slot       (slot),
        .hit_second (hit_second)
    );
endmodule

// File: rtl/hgm_checker.sv
// Port-level checker for the group matcher; it tracks its own view of
// whether a search is pending and how long it has run.
module hgm_checker
    import hgm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic             hit,
    input logic [IDXW-1:0]  slot,
    input logic [DW-1:0]    hit_second
);
    logic       pend;
    logic [4:0] cnt;

    // Model of an outstanding search and its elapsed edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            cnt  <= '0;
        end else if (done) begin
            pend <= start;
            cnt  <= '0;
        end else if (pend) begin
            cnt <= cnt + 1'b1;
        end else if (start) begin
            pend <= 1'b1;
            cnt  <= '0;
        end
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !done && !hit);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!hit && slot == '0 && hit_second == '0));

    // R7
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |-> (slot == '0 && hit_second == '0));

    // R6
    done_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pend);

    // R7
    bounded_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> cnt <= 5'(SLOTS));
endmodule

bind hpte_group_matcher hgm_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .done       (done),
    .hit        (hit),
    .slot       (slot),
    .hit_second (hit_second)
);

// File: tb/tb_hpte_group_matcher.sv
module tb_hpte_group_matcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [63:0] wr_first = '0;
    logic [63:0] wr_second = '0;
    logic        start = 1'b0;
    logic [63:0] target = '0;
    logic        sec_sel = 1'b0;
    logic        done, hit;
    logic [2:0]  slot;
    logic [63:0] hit_second;

    int n_tests = 0;
    int n_fail  = 0;

    int          r_lat;
    logic        r_hit;
    logic [2:0]  r_slot;
    logic [63:0] r_data;

    always #10 clk = ~clk;   // 50 MHz

    hpte_group_matcher dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_first(wr_first), .wr_second(wr_second), .start(start),
        .target(target), .sec_sel(sec_sel), .done(done), .hit(hit),
        .slot(slot), .hit_second(hit_second)
    );

    function automatic logic [63:0] key(input logic [1:0] ss, input logic [54:0] avpn);
        return {ss, avpn, 7'b0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic put(input int idx, input logic [63:0] f, input logic [63:0] s);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_first = f; wr_second = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic clear_group();
        for (int i = 0; i < 8; i++) put(i, 64'h0, 64'h0);
    endtask

    // Launch a search and wait for done; also checks the quiet cycles (R8).
    task automatic search(input logic [63:0] t, input logic sel);
        logic quiet_ok;
        @(negedge clk);
        start = 1'b1; target = t; sec_sel = sel;
        @(negedge clk);
        start = 1'b0;
        quiet_ok = 1'b1;
        if (done || hit || slot != 0 || hit_second != 0) quiet_ok = 1'b0;
        r_lat = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            r_lat++;
            if (done) break;
            if (hit || slot != 0 || hit_second != 0) quiet_ok = 1'b0;
        end
        r_hit = hit; r_slot = slot; r_data = hit_second;
        @(negedge clk);
        check("R8 quiet outputs while not done", {63'b0, quiet_ok}, 64'd1);
        check("R8 done is one cycle", {63'b0, done}, 64'd0);
    endtask

    task automatic t_reset();
        check("R1 done after reset", {63'b0, done}, 64'd0);
        check("R1 hit after reset", {63'b0, hit}, 64'd0);
        check("R1 slot after reset", {61'b0, slot}, 64'd0);
        check("R1 data after reset", hit_second, 64'd0);
    endtask

    task automatic t_basic();
        clear_group();
        put(3, key(2'b00, 55'h123456) | 64'h1, 64'hAAAA_0000_1234_5003);
        search(key(2'b00, 55'h123456), 1'b0);
        check("R6 hit slot 3", {63'b0, r_hit}, 64'd1);
        check("R6 slot index 3", {61'b0, r_slot}, 64'd3);
        check("R6 second doubleword", r_data, 64'hAAAA_0000_1234_5003);
        check("R6 latency slot 3", 64'(r_lat), 64'd4);
    endtask

    task automatic t_lowbits();
        clear_group();
        // large (bit2), lock (bit3), bolted (bit4), plus bits 5,6 in entry
        put(0, key(2'b01, 55'h0ABCDE) | 64'h7D, 64'h55);
        search(key(2'b01, 55'h0ABCDE) | 64'h44, 1'b0);
        check("R2 low flag bits ignored", {63'b0, r_hit}, 64'd1);
        check("R5 locked entry still matches", {61'b0, r_slot}, 64'd0);
        check("R2 data", r_data, 64'h55);
    endtask

    task automatic t_invalid();
        clear_group();
        put(1, key(2'b00, 55'h777), 64'h11);
        put(5, key(2'b00, 55'h777) | 64'h1, 64'h55);
        search(key(2'b00, 55'h777), 1'b0);
        check("R3 invalid slot skipped", {61'b0, r_slot}, 64'd5);
        check("R3 data from valid slot", r_data, 64'h55);
    endtask

    task automatic t_secondary();
        clear_group();
        put(2, key(2'b00, 55'h4242) | 64'h3, 64'h22);
        search(key(2'b00, 55'h4242), 1'b0);
        check("R4 secondary entry not hit by primary search", {63'b0, r_hit}, 64'd0);
        search(key(2'b00, 55'h4242), 1'b1);
        check("R4 secondary entry hit by secondary search", {63'b0, r_hit}, 64'd1);
        check("R4 slot", {61'b0, r_slot}, 64'd2);
    endtask

    task automatic t_first_wins();
        clear_group();
        put(6, key(2'b00, 55'h99) | 64'h1, 64'h66);
        put(2, key(2'b00, 55'h99) | 64'h1, 64'h22);
        search(key(2'b00, 55'h99), 1'b0);
        check("R6 lowest slot wins", {61'b0, r_slot}, 64'd2);
        check("R6 latency slot 2", 64'(r_lat), 64'd3);
    endtask

    task automatic t_last_slot();
        clear_group();
        put(7, key(2'b01, 55'h1) | 64'h1, 64'h77);
        search(key(2'b01, 55'h1), 1'b0);
        check("R6 slot 7", {61'b0, r_slot}, 64'd7);
        check("R6 latency slot 7", 64'(r_lat), 64'd8);
    endtask

    task automatic t_miss();
        clear_group();
        put(4, key(2'b00, 55'h5) | 64'h1, 64'h44);
        search(key(2'b00, 55'h6), 1'b0);
        check("R7 miss hit flag", {63'b0, r_hit}, 64'd0);
        check("R7 miss slot zero", {61'b0, r_slot}, 64'd0);
        check("R7 miss data zero", r_data, 64'd0);
        check("R7 miss latency", 64'(r_lat), 64'd8);
    endtask

    task automatic t_ssize();
        clear_group();
        put(0, key(2'b01, 55'h3C3C) | 64'h1, 64'h10);
        search(key(2'b00, 55'h3C3C), 1'b0);
        check("R10 segment size bit 62 compared", {63'b0, r_hit}, 64'd0);
    endtask

    task automatic t_busy_start();
        clear_group();
        put(1, key(2'b00, 55'hA1) | 64'h1, 64'h1A);
        put(6, key(2'b00, 55'hB2) | 64'h1, 64'h2B);
        @(negedge clk);
        start = 1'b1; target = key(2'b00, 55'hB2); sec_sel = 1'b0;
        @(negedge clk);
        target = key(2'b00, 55'hA1);   // second start during scan
        @(negedge clk);
        start = 1'b0;
        r_lat = 1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            r_lat++;
            if (done) break;
        end
        check("R9 running search keeps first target", {61'b0, slot}, 64'd6);
        check("R9 latency unchanged", 64'(r_lat), 64'd7);
        @(negedge clk);
        check("R9 no second result", {63'b0, done}, 64'd0);
    endtask

    task automatic t_overwrite();
        clear_group();
        put(3, key(2'b00, 55'hC0) | 64'h1, 64'hC0);
        put(3, key(2'b00, 55'hD0) | 64'h1, 64'hD0);
        search(key(2'b00, 55'hC0), 1'b0);
        check("R11 old contents gone", {63'b0, r_hit}, 64'd0);
        search(key(2'b00, 55'hD0), 1'b0);
        check("R11 new contents found", r_data, 64'hD0);
    endtask

    initial begin : watchdog
        #2000000;
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_lowbits();
        t_invalid();
        t_secondary();
        t_first_wins();
        t_last_slot();
        t_miss();
        t_ssize();
        t_busy_start();
        t_overwrite();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule